// File: doc/BRIEF.md
# Extended Mode Register Update Sequencer

This block lives in the command path of an SDRAM controller. Software-visible low-power settings are the partial-array refresh mask, the temperature-compensated refresh code and the output drive strength. When any of them changes, the sequencer rewrites the SDRAM extended mode register. It does not open a separate maintenance window for this. It appends the write to the next auto-refresh it runs.

A refresh begins with a precharge of every bank, then an auto refresh, and then, when a rewrite is pending, a mode register set aimed at the extended register. Each command is spaced from the previous one by a programmable number of clock cycles. Between refreshes the block forwards a row activation for the next access. Refresh takes priority over activation. When no settings change is pending, the mode register step is skipped.

The refresh interval timer, the data paths and device initialization belong to other blocks. The sequencer sees only a one-cycle refresh request, a one-cycle settings update carrying the new fields, the three spacing values and an activation request.

Top module: `emr_update_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the command output is NOP (encoding 0), the bank and address outputs are zero and act_grant is low.
- R2: A refresh request strobe, or one held from an earlier busy period, starts a sequence with PRECHARGE ALL (encoding 1) once the bus is free. It drives bank 0 and an address with only bit 10 set. Refresh wins over a waiting activation in the same cycle.
- R3: AUTO REFRESH (encoding 2) follows the precharge exactly max(1,t_rp) cycles later, and only NOP appears in between.
- R4: When a settings change was pending at the moment the precharge issued, MRS (encoding 3) follows the auto refresh exactly max(1,t_rfc) cycles later, with only NOP in between.
- R5: The MRS drives bank address 2, which selects the extended register. Address bits [2:0] carry the refresh mask, [4:3] the temperature code, [6:5] the drive strength, and all higher bits are zero.
- R6: When no change was pending at precharge time, no MRS is issued, and the next command may issue exactly max(1,t_rfc) cycles after the auto refresh.
- R7: After an MRS, only NOP appears until max(1,t_mrd) cycles have passed. The next command may issue on that cycle.
- R8: The pending-change flag is cleared only when an MRS issues. A settings update that arrives on or after the precharge cycle is held, and it is written at the following refresh using the newest field values.
- R9: A spacing value of 0 behaves as 1, so the two commands issue on consecutive cycles.
- R10: When the bus is free and no refresh is waiting, a held act_req produces ACTIVE (encoding 4) with the requested bank and row, and act_grant is high in that same cycle only.
- R11: In every cycle that carries NOP, the bank and address outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_req | input | 1 | One-cycle refresh request strobe |
| cfg_update | input | 1 | One-cycle strobe: new low-power fields are valid |
| cfg_pasr | input | 3 | New partial-array refresh mask |
| cfg_tcsr | input | 2 | New temperature-compensated refresh code |
| cfg_ds | input | 2 | New drive strength code |
| t_rp | input | CNT_W | Precharge-to-refresh spacing in cycles |
| t_rfc | input | CNT_W | Refresh-to-next-command spacing in cycles |
| t_mrd | input | CNT_W | Mode-register-set-to-next-command spacing in cycles |
| act_req | input | 1 | Activation wanted, held until granted |
| act_bank | input | BA_W | Bank for the activation |
| act_row | input | ROW_W | Row for the activation |
| cmd | output | 3 | SDRAM command: 0 NOP, 1 PRE ALL, 2 REF, 3 MRS, 4 ACT |
| ba | output | BA_W | SDRAM bank address |
| addr | output | ROW_W | SDRAM address bus |
| act_grant | output | 1 | High in the cycle the ACTIVE command is driven |

## Verification
The bench aims at the spacings at their extremes. Zero and one must both produce back-to-back commands, and a design off by one would put an extra NOP between commands or issue one a cycle early. It times settings updates to land on the precharge cycle and inside the refresh gaps. A design that cleared the pending flag on any refresh, or sampled it late, would lose or prematurely apply the newest fields. It also runs plain refreshes with an activation already waiting. This exposes a design that inserts a stray MRS, or that lets the activation overtake a refresh request arriving in the same cycle.

// File: rtl/emr_pkg.sv
package emr_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_PRE = 3'd1,
        CMD_REF = 3'd2,
        CMD_MRS = 3'd3,
        CMD_ACT = 3'd4
    } sdr_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_AFT_PRE = 2'd1,
        ST_AFT_REF = 2'd2,
        ST_AFT_MRS = 2'd3
    } seq_st_e;

    typedef struct packed {
        logic [1:0] ds;
        logic [1:0] tcsr;
        logic [2:0] pasr;
    } emr_fields_t;

    localparam int EMR_FIELD_W = $bits(emr_fields_t);
    localparam int EMR_BANK    = 2;
    localparam int AP_BIT      = 10;

endpackage

// File: rtl/emr_wait_timer.sv
module emr_wait_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load) begin
            // a length of zero is treated as one: zero residual wait
            t_d.cnt = (len == '0) ? '0 : len - CNT_W'(1);
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign expired = (t_q.cnt == '0);

endmodule

// File: rtl/emr_cfg_track.sv
module emr_cfg_track
    import emr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_update,
    input  logic [2:0]  cfg_pasr,
    input  logic [1:0]  cfg_tcsr,
    input  logic [1:0]  cfg_ds,
    input  logic        seq_start,
    input  logic        mrs_issue,
    output logic        seq_emr,
    output emr_fields_t snap
);
    typedef struct packed {
        emr_fields_t shadow;
        emr_fields_t snap;
        logic        pend;
        logic        late;
        logic        seq_emr;
    } trk_t;

    trk_t k_d, k_q;
    emr_fields_t incoming;

    always_comb begin
        incoming      = '0;
        incoming.pasr = cfg_pasr;
        incoming.tcsr = cfg_tcsr;
        incoming.ds   = cfg_ds;

        k_d = k_q;
        if (cfg_update) k_d.shadow = incoming;

        // pending flag drops only when the register is actually written
        if (mrs_issue) k_d.pend = k_q.late | cfg_update;
        else           k_d.pend = k_q.pend | cfg_update;

        if (seq_start) begin
            k_d.seq_emr = k_q.pend;
            k_d.snap    = k_q.shadow;
            k_d.late    = cfg_update;
        end else begin
            k_d.late    = k_q.late | cfg_update;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) k_q <= '0;
        else        k_q <= k_d;
    end

    assign seq_emr = k_q.seq_emr;
    assign snap    = k_q.snap;

endmodule

// File: rtl/emr_cmd_fmt.sv
module emr_cmd_fmt
    import emr_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int ROW_W = 13
) (
    input  sdr_cmd_e           cmd_sel,
    input  emr_fields_t        snap,
    input  logic [BA_W-1:0]    act_bank,
    input  logic [ROW_W-1:0]   act_row,
    output logic [BA_W-1:0]    ba,
    output logic [ROW_W-1:0]   addr
);
    logic [ROW_W-1:0] emr_word;
    logic [ROW_W-1:0] pre_word;

    generate
        if (ROW_W > EMR_FIELD_W) begin : g_pad
            assign emr_word = {{(ROW_W-EMR_FIELD_W){1'b0}}, snap};
        end else begin : g_trunc
            assign emr_word = snap[ROW_W-1:0];
        end
    endgenerate

    always_comb begin
        pre_word         = '0;
        pre_word[AP_BIT] = 1'b1;
    end

    always_comb begin
        ba   = '0;
        addr = '0;
        case (cmd_sel)
            CMD_PRE: addr = pre_word;
            CMD_MRS: begin
                ba   = BA_W'(EMR_BANK);
                addr = emr_word;
            end
            CMD_ACT: begin
                ba   = act_bank;
                addr = act_row;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/emr_update_seq.sv
module emr_update_seq
    import emr_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int BA_W  = 2,
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             refresh_req,
    input  logic             cfg_update,
    input  logic [2:0]       cfg_pasr,
    input  logic [1:0]       cfg_tcsr,
    input  logic [1:0]       cfg_ds,
    input  logic [CNT_W-1:0] t_rp,
    input  logic [CNT_W-1:0] t_rfc,
    input  logic [CNT_W-1:0] t_mrd,
    input  logic             act_req,
    input  logic [BA_W-1:0]  act_bank,
    input  logic [ROW_W-1:0] act_row,
    output logic [2:0]       cmd,
    output logic [BA_W-1:0]  ba,
    output logic [ROW_W-1:0] addr,
    output logic             act_grant
);
    typedef struct packed {
        seq_st_e          st;
        logic             ref_pend;
        logic [2:0]       cmd;
        logic [BA_W-1:0]  ba;
        logic [ROW_W-1:0] addr;
        logic             grant;
    } regs_t;

    regs_t r_d, r_q;

    logic             expired;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len;
    logic             seq_emr;
    emr_fields_t      snap;
    logic             bus_free;
    logic             seq_start;
    logic             mrs_issue;
    sdr_cmd_e         nxt_cmd;
    seq_st_e          nxt_st;
    logic [BA_W-1:0]  fmt_ba;
    logic [ROW_W-1:0] fmt_addr;

    emr_wait_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .len     (tmr_len),
        .expired (expired)
    );

    emr_cfg_track u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_update (cfg_update),
        .cfg_pasr   (cfg_pasr),
        .cfg_tcsr   (cfg_tcsr),
        .cfg_ds     (cfg_ds),
        .seq_start  (seq_start),
        .mrs_issue  (mrs_issue),
        .seq_emr    (seq_emr),
        .snap       (snap)
    );

    emr_cmd_fmt #(.BA_W(BA_W), .ROW_W(ROW_W)) u_fmt (
        .cmd_sel  (nxt_cmd),
        .snap     (snap),
        .act_bank (act_bank),
        .act_row  (act_row),
        .ba       (fmt_ba),
        .addr     (fmt_addr)
    );

    // control: choose the command for the next cycle
    always_comb begin
        bus_free = (r_q.st == ST_IDLE)
                || (r_q.st == ST_AFT_REF && expired && !seq_emr)
                || (r_q.st == ST_AFT_MRS && expired);
        nxt_cmd  = CMD_NOP;
        nxt_st   = r_q.st;
        tmr_load = 1'b0;
        tmr_len  = '0;
        if (bus_free) begin
            if (r_q.ref_pend || refresh_req) begin
                nxt_cmd  = CMD_PRE;
                nxt_st   = ST_AFT_PRE;
                tmr_load = 1'b1;
                tmr_len  = t_rp;
            end else if (act_req) begin
                nxt_cmd = CMD_ACT;
                nxt_st  = ST_IDLE;
            end else begin
                nxt_st  = ST_IDLE;
            end
        end else begin
            case (r_q.st)
                ST_AFT_PRE: if (expired) begin
                    nxt_cmd  = CMD_REF;
                    nxt_st   = ST_AFT_REF;
                    tmr_load = 1'b1;
                    tmr_len  = t_rfc;
                end
                ST_AFT_REF: if (expired) begin
                    nxt_cmd  = CMD_MRS;
                    nxt_st   = ST_AFT_MRS;
                    tmr_load = 1'b1;
                    tmr_len  = t_mrd;
                end
                default: ;
            endcase
        end
        seq_start = (nxt_cmd == CMD_PRE);
        mrs_issue = (nxt_cmd == CMD_MRS);
    end

    // assemble next register state
    always_comb begin
        r_d          = r_q;
        r_d.st       = nxt_st;
        r_d.ref_pend = seq_start ? 1'b0 : (r_q.ref_pend | refresh_req);
        r_d.cmd      = nxt_cmd;
        r_d.ba       = fmt_ba;
        r_d.addr     = fmt_addr;
        r_d.grant    = (nxt_cmd == CMD_ACT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmd       = r_q.cmd;
    assign ba        = r_q.ba;
    assign addr      = r_q.addr;
    assign act_grant = r_q.grant;

endmodule

// File: rtl/emr_update_seq_chk.sv
module emr_update_seq_chk #(
    parameter int CNT_W = 6,
    parameter int BA_W  = 2,
    parameter int ROW_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] t_rp,
    input logic [CNT_W-1:0] t_rfc,
    input logic [CNT_W-1:0] t_mrd,
    input logic             act_req,
    input logic [2:0]       cmd,
    input logic [BA_W-1:0]  ba,
    input logic [ROW_W-1:0] addr,
    input logic             act_grant
);
    localparam logic [2:0] C_NOP = 3'd0;
    localparam logic [2:0] C_PRE = 3'd1;
    localparam logic [2:0] C_REF = 3'd2;
    localparam logic [2:0] C_MRS = 3'd3;
    localparam logic [2:0] C_ACT = 3'd4;

    logic [2:0]     last_q;
    logic [CNT_W:0] gap_q;

    function automatic logic [CNT_W:0] eff(input logic [CNT_W-1:0] t);
        return (t == '0) ? (CNT_W+1)'(1) : {1'b0, t};
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= C_NOP;
            gap_q  <= '0;
        end else if (cmd != C_NOP) begin
            last_q <= cmd;
            gap_q  <= (CNT_W+1)'(1);
        end else if (gap_q != '1) begin
            gap_q  <= gap_q + (CNT_W+1)'(1);
        end
    end

    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == C_PRE |-> addr[10] && ba == '0); // R2
    AST_REF_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == C_REF |-> last_q == C_PRE && gap_q == eff(t_rp)); // R3
    AST_PRE_THEN_REF: assert property (@(posedge clk) disable iff (!rst_n)
        last_q == C_PRE && cmd != C_NOP |-> cmd == C_REF); // R3
    AST_MRS_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == C_MRS |-> last_q == C_REF && gap_q == eff(t_rfc)); // R4
    AST_MRS_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == C_MRS |-> ba == BA_W'(2) && addr[ROW_W-1:7] == '0); // R5
    AST_REF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        last_q == C_REF && cmd != C_NOP |-> gap_q >= eff(t_rfc)); // R6
    AST_MRS_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        last_q == C_MRS && cmd != C_NOP |-> gap_q >= eff(t_mrd)); // R7
    AST_GRANT_IS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        act_grant |-> cmd == C_ACT && $past(act_req)); // R10
    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == C_NOP |-> ba == '0 && addr == '0 && !act_grant); // R11

endmodule

bind emr_update_seq emr_update_seq_chk #(.CNT_W(CNT_W), .BA_W(BA_W), .ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .t_rp      (t_rp),
    .t_rfc     (t_rfc),
    .t_mrd     (t_mrd),
    .act_req   (act_req),
    .cmd       (cmd),
    .ba        (ba),
    .addr      (addr),
    .act_grant (act_grant)
);

// File: tb/emr_update_seq_tb.sv
module emr_update_seq_tb;
    localparam int CNT_W = 6;
    localparam int BA_W  = 2;
    localparam int ROW_W = 13;

    localparam logic [2:0] C_NOP = 3'd0, C_PRE = 3'd1, C_REF = 3'd2,
                           C_MRS = 3'd3, C_ACT = 3'd4;
    localparam int PH_IDLE = 0, PH_PRE = 1, PH_REF = 2, PH_MRS = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic refresh_req = 1'b0, cfg_update = 1'b0, act_req = 1'b0;
    logic [2:0] cfg_pasr = '0;
    logic [1:0] cfg_tcsr = '0, cfg_ds = '0;
    logic [CNT_W-1:0] t_rp = 6'd1, t_rfc = 6'd1, t_mrd = 6'd1;
    logic [BA_W-1:0] act_bank = '0;
    logic [ROW_W-1:0] act_row = '0;
    logic [2:0] cmd;
    logic [BA_W-1:0] ba;
    logic [ROW_W-1:0] addr;
    logic act_grant;

    always #2 clk = ~clk;

    emr_update_seq #(.CNT_W(CNT_W), .BA_W(BA_W), .ROW_W(ROW_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .refresh_req(refresh_req), .cfg_update(cfg_update),
        .cfg_pasr(cfg_pasr), .cfg_tcsr(cfg_tcsr), .cfg_ds(cfg_ds),
        .t_rp(t_rp), .t_rfc(t_rfc), .t_mrd(t_mrd),
        .act_req(act_req), .act_bank(act_bank), .act_row(act_row),
        .cmd(cmd), .ba(ba), .addr(addr), .act_grant(act_grant)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model state
    int m_ph = PH_IDLE, m_el = 0, m_T = 1;
    bit m_ref = 0, m_pend = 0, m_late = 0, m_emr = 0;
    logic [6:0] m_shadow = '0, m_snap = '0;
    int n_mrs = 0, n_plain = 0, n_held = 0, n_zero = 0;

    function automatic int eff(input logic [CNT_W-1:0] t);
        return (t == '0) ? 1 : int'(t);
    endfunction

    task automatic check(input string tag, input logic [2:0] ec, input logic [BA_W-1:0] eb,
                         input logic [ROW_W-1:0] ea, input logic eg);
        n_chk++;
        if (cmd !== ec || ba !== eb || addr !== ea || act_grant !== eg) begin
            n_bad++;
            $display("FAIL %s: got cmd=%0d ba=%0d addr=%h grant=%0b exp cmd=%0d ba=%0d addr=%h grant=%0b",
                     tag, cmd, ba, addr, act_grant, ec, eb, ea, eg);
        end
    endtask

    task automatic cover_chk(input string tag, input bit ok, input int got);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got count=%0d exp nonzero", tag, got);
        end
    endtask

    // one cycle: compare outputs with the model, advance the model, clear strobes
    task automatic step();
        logic [2:0] ec;
        logic [BA_W-1:0] eb;
        logic [ROW_W-1:0] ea;
        bit free;
        string tag;
        @(negedge clk);
        if (m_el < 100000) m_el++;
        free = (m_ph == PH_IDLE) || (m_ph == PH_REF && m_el >= m_T && !m_emr)
            || (m_ph == PH_MRS && m_el >= m_T);
        ec = C_NOP; eb = '0; ea = '0;
        if (free) begin
            if (m_ref || refresh_req) begin ec = C_PRE; ea[10] = 1'b1; end
            else if (act_req) begin ec = C_ACT; eb = act_bank; ea = act_row; end
        end else if (m_ph == PH_PRE && m_el >= m_T) ec = C_REF;
        else if (m_ph == PH_REF && m_emr && m_el >= m_T) begin
            ec = C_MRS; eb = 2'd2; ea = {6'd0, m_snap};
        end
        case (ec)
            C_PRE: tag = "R2";
            C_REF: tag = (m_T == 1) ? "R3/R9" : "R3";
            C_MRS: tag = "R5";
            C_ACT: tag = "R10";
            default: tag = (m_ph == PH_PRE) ? "R3" : (m_ph == PH_REF) ? (m_emr ? "R4" : "R6")
                         : (m_ph == PH_MRS) ? "R7" : "R11";
        endcase
        check(tag, ec, eb, ea, ec == C_ACT);

        if (ec != C_NOP) m_el = 0;
        if (ec == C_PRE) begin
            m_ph = PH_PRE; m_T = eff(t_rp); m_emr = m_pend; m_snap = m_shadow;
            m_late = cfg_update; m_ref = 0;
            if (t_rp == '0) n_zero++;
        end else begin
            m_late = m_late | cfg_update;
            m_ref  = m_ref | refresh_req;
        end
        if (ec == C_REF) begin
            m_ph = PH_REF; m_T = eff(t_rfc);
            if (!m_emr) n_plain++;
        end
        if (ec == C_MRS) begin
            m_ph = PH_MRS; m_T = eff(t_mrd); n_mrs++;
            if (m_late) n_held++;
            m_pend = m_late | cfg_update;
        end else begin
            m_pend = m_pend | cfg_update;
        end
        if (ec == C_ACT) m_ph = PH_IDLE;
        if (cfg_update) m_shadow = {cfg_ds, cfg_tcsr, cfg_pasr};

        refresh_req = 1'b0;
        cfg_update  = 1'b0;
        if (ec == C_ACT) act_req = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic set_cfg(input logic [6:0] v);
        cfg_update = 1'b1;
        {cfg_ds, cfg_tcsr, cfg_pasr} = v;
    endtask

    task automatic set_act();
        act_req  = 1'b1;
        act_bank = BA_W'($urandom);
        act_row  = ROW_W'($urandom);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            check("R1", C_NOP, '0, '0, 1'b0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        step();

        // R9: zero spacings, change pending, activation waiting behind refresh
        t_rp = 6'd0; t_rfc = 6'd0; t_mrd = 6'd0;
        set_cfg(7'h5A);
        step();
        refresh_req = 1'b1;
        set_act();
        idle(10);

        // R6: plain refresh with activation queued at the refresh gap
        t_rp = 6'd3; t_rfc = 6'd4; t_mrd = 6'd2;
        idle(3);
        refresh_req = 1'b1;
        set_act();
        idle(15);

        // R8: change on the precharge cycle and inside the gap is held
        set_cfg(7'h11);
        step();
        refresh_req = 1'b1;
        set_cfg(7'h22);
        step();
        step();
        set_cfg(7'h33);
        idle(20);
        refresh_req = 1'b1;
        idle(20);

        // random traffic with quiet windows for spacing changes
        for (int blk = 0; blk < 12; blk++) begin
            for (int c = 0; c < 1500; c++) begin
                if ($urandom % 37 == 0) refresh_req = 1'b1;
                if ($urandom % 29 == 0) set_cfg(7'($urandom));
                if (!act_req && $urandom % 9 == 0) set_act();
                step();
            end
            while (act_req) step();
            idle(100);
            t_rp  = CNT_W'($urandom % 10);
            t_rfc = CNT_W'($urandom % 10);
            t_mrd = CNT_W'($urandom % 10);
        end

        cover_chk("R4 MRS seen", n_mrs > 0, n_mrs);
        cover_chk("R6 plain refresh seen", n_plain > 0, n_plain);
        cover_chk("R8 held change seen", n_held > 0, n_held);
        cover_chk("R9 zero spacing seen", n_zero > 0, n_zero);

        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got run still active exp finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule